// File: doc/BRIEF.md
# Frame Sync Arm Controller

This block turns a sync-pulse input into a one-cycle frame-synchronization event. Downstream logic uses that event to realign its dividers. Two reference pairs are available, and a 1-bit pair select chooses which pair's sync pulse counts. Each pair is a clock reference with a companion sync-pulse line: reference A goes with sync line B, and reference C goes with sync line D. The sync lines and an external arm pin are asynchronous. Each passes through a two-flop synchronizer before its edges are detected.

A small register file sets the behaviour. Writes go into a shadow copy, and an I/O update strobe moves the shadow copy into active use. The active settings choose between two trigger modes. In level-sensitive mode every rising edge of the selected sync line produces an event. In one-shot mode only the first rising edge after arming produces one. Arming comes from one of two sources. The first is a high-then-low sequence on the arm pin. The second is a software arm bit that takes effect on an I/O update. The block also drives a qualified reference-valid output. When validation is enabled, this output requires the selected reference and its sync line to be valid at the same time.

Top module: `fsync_ctrl`

## Requirements
- R1: The active enable bit (address 0, bit 0) resets to 0. While it is 0, `fsync_evt` stays low and `armed` reads 0 from the cycle after it drops.
- R2: In level-sensitive mode (one-shot bit 0), each rising edge of the selected sync line gives a `fsync_evt` pulse exactly one cycle wide. The pulse appears on the third rising clock edge after the line goes high.
- R3: In one-shot mode (address 1, bit 1 set), a rising edge on the sync line produces an event only while `armed` is 1. Edges arriving while unarmed are ignored.
- R4: The arm-source bit (address 1, bit 2) selects the arm source, and it resets to 0. With the bit at 0, a high-then-low sequence on `sync_pin` sets `armed` on the third clock edge after the pin falls.
- R5: With the arm-source bit at 1, an I/O update that changes the software arm bit (address 1, bit 3) from 0 to 1 sets `armed` two clock edges after the update is sampled. An update that leaves the bit at 1 does not re-arm. Re-arming needs the bit to be cleared and then set again.
- R6: The software arm bit has no effect while the arm-source bit is 0. The pin has no effect while the arm-source bit is 1.
- R7: Writes through `wr_en`/`wr_addr`/`wr_data` change only the shadow copy. Behaviour changes only after an `io_update` cycle.
- R8: `ref_ok` is a combinational output. With the validate bit (address 1, bit 0) at 0, it equals the selected reference's valid bit. With the bit at 1, it is that bit ANDed with the valid bit of the paired sync line. The bits of `ref_vld` are indexed 0=A, 1=B, 2=C, 3=D.
- R9: In one-shot mode, `armed` falls in the same cycle that `fsync_evt` rises.
- R10: `pair_sel`=0 lets only `pulse_b` trigger events, and `pair_sel`=1 lets only `pulse_d` trigger them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register address (0 = enable, 1 = control) |
| wr_data | input | 4 | Register write data |
| io_update | input | 1 | Copies the shadow registers into the active registers |
| sync_pin | input | 1 | Asynchronous arm pin |
| pulse_b | input | 1 | Asynchronous sync line paired with reference A |
| pulse_d | input | 1 | Asynchronous sync line paired with reference C |
| pair_sel | input | 1 | 0 selects pair A/B, 1 selects pair C/D |
| ref_vld | input | 4 | Raw valid flags: bit 0 A, bit 1 B, bit 2 C, bit 3 D |
| fsync_evt | output | 1 | One-cycle frame sync event |
| armed | output | 1 | Arm state |
| ref_ok | output | 1 | Qualified valid flag of the selected reference |

## Verification
A rising edge on a sync line passes through two synchronizer flops and then the event register. The event is therefore due in the third cycle after the line is driven, and the fourth cycle must show it low again. Both cycles are pushed into the scoreboard with the cycle index at which they are due. A falling arm pin sets `armed` three cycles later, and a software arm sets it two cycles after the update cycle. The checks sample only after those counts have elapsed. `ref_ok` is combinational and is checked one time step after its inputs change.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
    localparam int unsigned ADDR_ENABLE = 0;
    localparam int unsigned ADDR_CTRL   = 1;
    localparam int unsigned BIT_VALID   = 0;
    localparam int unsigned BIT_ONESHOT = 1;
    localparam int unsigned BIT_ARMSEL  = 2;
    localparam int unsigned BIT_SWARM   = 3;
    localparam int unsigned CTRL_BITS   = 4;

    typedef struct packed {
        logic enable;
        logic validate;
        logic oneshot;
        logic arm_sel;
        logic sw_arm;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{default: 1'b0};
endpackage

// File: rtl/fsync_regs.sv
module fsync_regs
    import fsync_pkg::*;
#(
    parameter int unsigned ADDR_W = 1,
    parameter int unsigned DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              io_update,
    output ctrl_t             act,
    output logic              sw_set
);
    typedef struct packed {
        ctrl_t shadow;
        ctrl_t active;
        logic  sw_set;
    } reg_state_t;

    reg_state_t s_d, s_q;
    logic eff_new, eff_old;

    always_comb begin
        s_d        = s_q;
        s_d.sw_set = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(ADDR_ENABLE)) begin
                s_d.shadow.enable = wr_data[0];
            end else if (wr_addr == ADDR_W'(ADDR_CTRL)) begin
                s_d.shadow.validate = wr_data[BIT_VALID];
                s_d.shadow.oneshot  = wr_data[BIT_ONESHOT];
                s_d.shadow.arm_sel  = wr_data[BIT_ARMSEL];
                s_d.shadow.sw_arm   = wr_data[BIT_SWARM];
            end
        end
        eff_new = s_q.shadow.sw_arm & s_q.shadow.arm_sel;
        eff_old = s_q.active.sw_arm & s_q.active.arm_sel;
        if (io_update) begin
            s_d.active = s_q.shadow;
            s_d.sw_set = eff_new & ~eff_old;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{shadow: CTRL_RESET, active: CTRL_RESET, sw_set: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign act    = s_q.active;
    assign sw_set = s_q.sw_set;
endmodule

// File: rtl/fsync_sync.sv
module fsync_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int unsigned DEPTH = STAGES + 1;

    for (genvar i = 0; i < W; i++) begin : g_line
        logic [DEPTH-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[DEPTH-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= pipe_d;
            end
        end

        assign rise[i] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall[i] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/fsync_arm.sv
module fsync_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic oneshot,
    input  logic arm_req,
    input  logic trig,
    output logic evt,
    output logic armed
);
    typedef struct packed {
        logic armed;
        logic evt;
    } arm_state_t;

    arm_state_t s_d, s_q;
    logic consume;

    always_comb begin
        s_d     = s_q;
        consume = trig & oneshot & s_q.armed;
        s_d.evt = en & trig & (~oneshot | s_q.armed);
        if (!en) begin
            s_d.armed = 1'b0;
        end else if (arm_req) begin
            s_d.armed = 1'b1;
        end else if (consume) begin
            s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign evt   = s_q.evt;
    assign armed = s_q.armed;
endmodule

// File: rtl/fsync_ctrl.sv
module fsync_ctrl
    import fsync_pkg::*;
#(
    parameter int unsigned ADDR_W      = 1,
    parameter int unsigned DATA_W      = CTRL_BITS,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              io_update,
    input  logic              sync_pin,
    input  logic              pulse_b,
    input  logic              pulse_d,
    input  logic              pair_sel,
    input  logic [3:0]        ref_vld,
    output logic              fsync_evt,
    output logic              armed,
    output logic              ref_ok
);
    localparam int unsigned NLINES = 3;
    localparam int unsigned L_PIN  = 0;
    localparam int unsigned L_B    = 1;
    localparam int unsigned L_D    = 2;

    ctrl_t              act;
    logic               sw_set;
    logic [NLINES-1:0]  rise, fall;
    logic               trig, arm_req;
    logic               en_act, os_act, val_act;
    logic               ref_raw, pulse_vld;

    fsync_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .io_update (io_update),
        .act       (act),
        .sw_set    (sw_set)
    );

    fsync_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pulse_d, pulse_b, sync_pin}),
        .rise  (rise),
        .fall  (fall)
    );

    always_comb begin
        en_act    = act.enable;
        os_act    = act.oneshot;
        val_act   = act.validate;
        trig      = pair_sel ? rise[L_D] : rise[L_B];
        arm_req   = act.arm_sel ? sw_set : fall[L_PIN];
        ref_raw   = pair_sel ? ref_vld[2] : ref_vld[0];
        pulse_vld = pair_sel ? ref_vld[3] : ref_vld[1];
        ref_ok    = ref_raw & (~val_act | pulse_vld);
    end

    fsync_arm u_arm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_act),
        .oneshot (os_act),
        .arm_req (arm_req),
        .trig    (trig),
        .evt     (fsync_evt),
        .armed   (armed)
    );

    logic unused_ok;
    assign unused_ok = &{1'b0, rise[L_PIN], fall[L_B], fall[L_D]};
endmodule

// File: rtl/fsync_ctrl_chk.sv
module fsync_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fsync_evt,
    input logic       armed,
    input logic       en_act,
    input logic       os_act,
    input logic       val_act,
    input logic       arm_req,
    input logic       pair_sel,
    input logic [3:0] ref_vld,
    input logic       ref_ok
);
    // R1
    no_evt_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_act) |-> !fsync_evt);

    // R1
    no_arm_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_act) |-> !armed);

    // R2
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_evt |=> !fsync_evt);

    // R3
    oneshot_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_evt && $past(os_act)) |-> $past(armed));

    // R9
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync_evt && $past(os_act) && !$past(arm_req)) |-> !armed);

    // R8
    ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_act && ((!pair_sel && !ref_vld[1]) || (pair_sel && !ref_vld[3]))) |-> !ref_ok);
endmodule

bind fsync_ctrl fsync_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fsync_evt (fsync_evt),
    .armed     (armed),
    .en_act    (en_act),
    .os_act    (os_act),
    .val_act   (val_act),
    .arm_req   (arm_req),
    .pair_sel  (pair_sel),
    .ref_vld   (ref_vld),
    .ref_ok    (ref_ok)
);

// File: tb/fsync_ctrl_bench.sv
module fsync_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_addr = '0;
    logic [3:0] wr_data = '0;
    logic       io_update = 1'b0;
    logic       sync_pin = 1'b0;
    logic       pulse_b = 1'b0;
    logic       pulse_d = 1'b0;
    logic       pair_sel = 1'b0;
    logic [3:0] ref_vld = '0;
    logic       fsync_evt, armed, ref_ok;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        int    due;
        logic  evt;
        logic  arm;
        string req;
    } exp_t;

    exp_t sb[$];

    fsync_ctrl u_fsync_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .io_update(io_update), .sync_pin(sync_pin),
        .pulse_b(pulse_b), .pulse_d(pulse_d), .pair_sel(pair_sel),
        .ref_vld(ref_vld), .fsync_evt(fsync_evt), .armed(armed), .ref_ok(ref_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    // monitor: pops expected items when their cycle is reached
    always @(negedge clk) begin : monitor
        exp_t e;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            e = sb.pop_front();
            if (e.due < cyc) begin
                chk(e.req, "missed slot", cyc, e.due);
            end else begin
                chk(e.req, "fsync_evt", int'(fsync_evt), int'(e.evt));
                chk(e.req, "armed", int'(armed), int'(e.arm));
            end
        end
    end

    task automatic push(input int due, input logic ev, input logic ar, input string req);
        exp_t e;
        e.due = due; e.evt = ev; e.arm = ar; e.req = req;
        sb.push_back(e);
    endtask

    task automatic wr(input logic a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic upd();
        @(negedge clk);
        io_update = 1'b1;
        @(negedge clk);
        io_update = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // line 0 drives pulse_b, line 1 drives pulse_d
    task automatic pulse(input int line, input logic ev, input logic ar, input string req);
        @(negedge clk);
        if (line == 0) pulse_b = 1'b1; else pulse_d = 1'b1;
        push(cyc + 3, ev, ar, req);
        push(cyc + 4, 1'b0, ar, req);
        repeat (5) @(negedge clk);
        pulse_b = 1'b0; pulse_d = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pin_arm(input logic ar, input string req);
        @(negedge clk);
        sync_pin = 1'b1;
        repeat (4) @(negedge clk);
        sync_pin = 1'b0;
        push(cyc + 3, 1'b0, ar, req);
        repeat (5) @(negedge clk);
    endtask

    task automatic chk_ref(input logic exp, input string req);
        #1;
        chk(req, "ref_ok", int'(ref_ok), int'(exp));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        chk("R1", "reset fsync_evt", int'(fsync_evt), 0);
        chk("R1", "reset armed", int'(armed), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: disabled by default
        pulse(0, 1'b0, 1'b0, "R1");
        // R7: enable only in shadow
        wr(1'b0, 4'b0001);
        pulse(0, 1'b0, 1'b0, "R7");
        upd();
        // R2: level mode, repeated edges
        pulse(0, 1'b1, 1'b0, "R2");
        pulse(0, 1'b1, 1'b0, "R2");
        // R10: pair selection
        pulse(1, 1'b0, 1'b0, "R10");
        pair_sel = 1'b1;
        pulse(1, 1'b1, 1'b0, "R10");
        pulse(0, 1'b0, 1'b0, "R10");
        pair_sel = 1'b0;

        // one-shot, pin arming
        wr(1'b1, 4'b0010);
        upd();
        pulse(0, 1'b0, 1'b0, "R3");
        pin_arm(1'b1, "R4");
        pulse(0, 1'b1, 1'b0, "R9");
        pulse(0, 1'b0, 1'b0, "R3");
        pin_arm(1'b1, "R4");
        pulse(0, 1'b1, 1'b0, "R3");

        // R6: soft arm ignored with pin method
        wr(1'b1, 4'b1010);
        upd();
        chk("R6", "armed soft bit under pin method", int'(armed), 0);
        // R6: pin ignored with soft method
        wr(1'b1, 4'b0110);
        upd();
        pin_arm(1'b0, "R6");

        // R5: software arming
        wr(1'b1, 4'b1110);
        upd();
        chk("R5", "armed after soft arm", int'(armed), 1);
        pulse(0, 1'b1, 1'b0, "R5");
        upd();
        chk("R5", "no re-arm without clear", int'(armed), 0);
        wr(1'b1, 4'b0110);
        upd();
        wr(1'b1, 4'b1110);
        upd();
        chk("R5", "armed after clear and set", int'(armed), 1);
        pulse(0, 1'b1, 1'b0, "R5");

        // R8: reference qualification
        ref_vld = 4'b0001;
        chk_ref(1'b1, "R8");
        wr(1'b1, 4'b0111);
        chk_ref(1'b1, "R7");
        upd();
        chk_ref(1'b0, "R8");
        ref_vld = 4'b0011;
        chk_ref(1'b1, "R8");
        pair_sel = 1'b1;
        ref_vld = 4'b0100;
        chk_ref(1'b0, "R8");
        ref_vld = 4'b1100;
        chk_ref(1'b1, "R8");

        // R1: disable clears arm and blocks events
        wr(1'b1, 4'b0110);
        upd();
        wr(1'b1, 4'b1110);
        upd();
        chk("R5", "armed before disable", int'(armed), 1);
        wr(1'b0, 4'b0000);
        upd();
        chk("R1", "armed after disable", int'(armed), 0);
        pulse(1, 1'b0, 1'b0, "R1");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) chk("R2", "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule